// File: doc/BRIEF.md
# Repeated Element Copy Sequencer

This block moves a run of elements from one region of a shared memory to another. The element is either a single byte or a 32-bit word. A start pulse loads three working registers: the remaining element count, the source pointer and the destination pointer. The sequencer then handles one element at a time through a fixed five-step schedule. It reads the source, writes the destination, then bumps the source pointer, bumps the destination pointer and decrements the count, each in a cycle of its own. It stops when the count reaches zero.

The block drives one synchronous single-port memory with byte addressing, a 32-bit data path and per-byte write enables. The memory answers a read on the following cycle. In byte mode only the addressed byte lane of the destination is written. In word mode both pointers must be multiples of four. When a copy finishes, the final register contents stay visible on dedicated outputs. Software-level users see a plain start/busy/done handshake.

Top module: `strmove_engine`

## Requirements
- R1: Synchronous active-high reset, applied while idle or in the middle of a copy, leaves busy, done and the memory request low on the next cycle.
- R2: Start is accepted only while the engine is idle. A start pulse while busy, including the done cycle, does not restart a copy. Load inputs that change after acceptance have no effect.
- R3: A start with count zero raises done in the first cycle after the start edge. It makes no memory access and leaves count, source and destination equal to their loaded values.
- R4: Byte mode (size_word=0) copies the byte in lane src[1:0] of the source word into lane dst[1:0] of the destination word. Lane i occupies data bits [8i+7:8i]. The write enable has exactly bit dst[1:0] set, and every other destination byte is kept.
- R5: Word mode (size_word=1) copies the whole 32-bit word with all four byte enables set.
- R6: After a copy of N elements, src_out and dst_out equal their start values plus N times the stride. The stride is 1 in byte mode and 4 in word mode.
- R7: The count drops by exactly one per element and reads zero after a copy.
- R8: Each element takes five cycles. For N elements, done is high in cycle 5N+1 after the start edge.
- R9: Busy is high from the cycle after an accepted start through the done cycle. Done lasts exactly one cycle, and busy is low after it.
- R10: Each element makes exactly one read of the source, followed in the next cycle by exactly one write to the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a copy |
| size_word | input | 1 | Element size: 0 byte, 1 word |
| cnt_in | input | CW | Number of elements to copy |
| src_in | input | AW | Source byte address |
| dst_in | input | AW | Destination byte address |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_be | output | DW/8 | Byte write enables |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one cycle after a read |
| cnt_out | output | CW | Current count register |
| src_out | output | AW | Current source pointer |
| dst_out | output | AW | Current destination pointer |

## Verification
Two functions can land in the same cycle: a fresh start request and the completion of a running copy. The done cycle is the last one in which the engine is still busy, so a start there must be dropped. The bench raises start exactly in the done cycle of several copies, and also partway through. It then checks that busy falls on the next cycle and that the memory image, final pointers and access counts match a bench-side element-by-element model of the copy that was actually requested.

// File: rtl/strmove_pkg.sv
package strmove_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_USRC,
    ST_UDST,
    ST_UCNT,
    ST_DONE
  } step_e;
endpackage

// File: rtl/strmove_seq.sv
module strmove_seq
  import strmove_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cnt_in_zero,
  input  logic cnt_at_one,
  output logic accept,
  output logic rd_evt,
  output logic wr_evt,
  output logic usrc_evt,
  output logic udst_evt,
  output logic ucnt_evt,
  output logic busy,
  output logic done
);
  step_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = cnt_in_zero ? ST_DONE : ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_USRC;
      ST_USRC:  state_d = ST_UDST;
      ST_UDST:  state_d = ST_UCNT;
      ST_UCNT:  state_d = cnt_at_one ? ST_DONE : ST_READ;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign accept   = (state_q == ST_IDLE) && start;
  assign rd_evt   = (state_q == ST_READ);
  assign wr_evt   = (state_q == ST_WRITE);
  assign usrc_evt = (state_q == ST_USRC);
  assign udst_evt = (state_q == ST_UDST);
  assign ucnt_evt = (state_q == ST_UCNT);
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);

  // R9: done is a single-cycle pulse that returns the engine to idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  // R2: once running, the engine stays busy until its own done
  a_r2_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

  // R3: a zero-count start completes on the next cycle without memory traffic
  a_r3_zero_done: assert property (@(posedge clk) disable iff (rst)
    (accept && cnt_in_zero) |=> (done && !rd_evt && !wr_evt));
endmodule

// File: rtl/strmove_regs.sv
module strmove_regs #(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int LANES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          word_in,
  input  logic [CW-1:0] cnt_in,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic          usrc_evt,
  input  logic          udst_evt,
  input  logic          ucnt_evt,
  output logic [CW-1:0] cnt_q,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic          word_q,
  output logic          cnt_at_one
);
  function automatic logic [AW-1:0] advance(input logic [AW-1:0] p, input logic w);
    return p + (w ? AW'(LANES) : AW'(1));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      word_q <= 1'b0;
    end else if (accept) begin
      cnt_q  <= cnt_in;
      src_q  <= src_in;
      dst_q  <= dst_in;
      word_q <= word_in;
    end else begin
      if (usrc_evt) src_q <= advance(src_q, word_q);
      if (udst_evt) dst_q <= advance(dst_q, word_q);
      if (ucnt_evt) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign cnt_at_one = (cnt_q == CW'(1));

  // R7: one decrement per element
  a_r7_cnt_dec: assert property (@(posedge clk) disable iff (rst)
    ucnt_evt |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R6: destination pointer moves by the element stride
  a_r6_dst_step: assert property (@(posedge clk) disable iff (rst)
    udst_evt |=> (dst_q - $past(dst_q) == (word_q ? AW'(LANES) : AW'(1))));
endmodule

// File: rtl/strmove_lane.sv
module strmove_lane #(
  parameter int DW    = 32,
  parameter int LANES = DW / 8,
  parameter int LSB   = $clog2(LANES)
) (
  input  logic             word,
  input  logic [LSB-1:0]   src_lane,
  input  logic [LSB-1:0]   dst_lane,
  input  logic [DW-1:0]    rdata,
  output logic [DW-1:0]    wdata,
  output logic [LANES-1:0] be
);
  logic [7:0]       pick;
  logic [LANES-1:0] one_lane;

  always_comb begin
    pick     = 8'h00;
    one_lane = '0;
    for (int i = 0; i < LANES; i++) begin
      if (src_lane == LSB'(i)) pick = rdata[8*i +: 8];
      if (dst_lane == LSB'(i)) one_lane[i] = 1'b1;
    end
  end

  assign wdata = word ? rdata : {LANES{pick}};
  assign be    = word ? {LANES{1'b1}} : one_lane;
endmodule

// File: rtl/strmove_engine.sv
module strmove_engine #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              size_word,
  input  logic [CW-1:0]     cnt_in,
  input  logic [AW-1:0]     src_in,
  input  logic [AW-1:0]     dst_in,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW/8-1:0]   mem_be,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic [CW-1:0]     cnt_out,
  output logic [AW-1:0]     src_out,
  output logic [AW-1:0]     dst_out
);
  localparam int LANES = DW / 8;
  localparam int LSB   = $clog2(LANES);

  logic accept, rd_evt, wr_evt, usrc_evt, udst_evt, ucnt_evt;
  logic cnt_at_one, word_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] src_q, dst_q;
  logic [DW-1:0] lane_wdata;
  logic [LANES-1:0] lane_be;

  strmove_seq u_seq (
    .clk(clk), .rst(rst), .start(start),
    .cnt_in_zero(cnt_in == '0), .cnt_at_one(cnt_at_one),
    .accept(accept), .rd_evt(rd_evt), .wr_evt(wr_evt),
    .usrc_evt(usrc_evt), .udst_evt(udst_evt), .ucnt_evt(ucnt_evt),
    .busy(busy), .done(done)
  );

  strmove_regs #(.AW(AW), .CW(CW), .LANES(LANES)) u_regs (
    .clk(clk), .rst(rst), .accept(accept), .word_in(size_word),
    .cnt_in(cnt_in), .src_in(src_in), .dst_in(dst_in),
    .usrc_evt(usrc_evt), .udst_evt(udst_evt), .ucnt_evt(ucnt_evt),
    .cnt_q(cnt_q), .src_q(src_q), .dst_q(dst_q),
    .word_q(word_q), .cnt_at_one(cnt_at_one)
  );

  strmove_lane #(.DW(DW), .LANES(LANES), .LSB(LSB)) u_lane (
    .word(word_q), .src_lane(src_q[LSB-1:0]), .dst_lane(dst_q[LSB-1:0]),
    .rdata(mem_rdata), .wdata(lane_wdata), .be(lane_be)
  );

  assign mem_req   = rd_evt | wr_evt;
  assign mem_we    = wr_evt;
  assign mem_addr  = wr_evt ? dst_q : src_q;
  assign mem_be    = wr_evt ? lane_be : {LANES{1'b1}};
  assign mem_wdata = lane_wdata;
  assign cnt_out   = cnt_q;
  assign src_out   = src_q;
  assign dst_out   = dst_q;

  // R10: every write is immediately preceded by a read
  a_r10_rd_before_wr: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> $past(mem_req && !mem_we));

  // R4: byte writes touch a single lane
  a_r4_byte_lane: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !word_q) |-> ($countones(mem_be) == 1));

  // R5: word writes enable every lane
  a_r5_word_be: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && word_q) |-> (mem_be == {LANES{1'b1}}));
endmodule

// File: tb/tb_strmove_engine.sv
module tb_strmove_engine;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic size_word = 1'b0;
  logic [CW-1:0] cnt_in = '0;
  logic [AW-1:0] src_in = '0, dst_in = '0;
  logic busy, done, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [CW-1:0] cnt_out;
  logic [AW-1:0] src_out, dst_out;

  int errors = 0;
  int checks = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int cycles = 0;

  logic [31:0] mem [0:255];
  logic [7:0]  ref_b [0:1023];

  always #10 clk = ~clk;

  strmove_engine #(.AW(AW), .CW(CW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .start(start), .size_word(size_word),
    .cnt_in(cnt_in), .src_in(src_in), .dst_in(dst_in),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .cnt_out(cnt_out), .src_out(src_out), .dst_out(dst_out)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        wr_cnt <= wr_cnt + 1;
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem[mem_addr[9:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
      end else begin
        rd_cnt <= rd_cnt + 1;
        mem_rdata <= mem[mem_addr[9:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int stride_of(input bit w);
    return w ? 4 : 1;
  endfunction

  task automatic ref_copy(input int n, input int s, input int d, input bit w);
    for (int e = 0; e < n; e++)
      for (int b = 0; b < stride_of(w); b++)
        ref_b[d + e*stride_of(w) + b] = ref_b[s + e*stride_of(w) + b];
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    for (int w = 0; w < 256; w++)
      if (mem[w] !== {ref_b[4*w+3], ref_b[4*w+2], ref_b[4*w+1], ref_b[4*w]}) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  // Runs one copy; poke raises start mid-run and in the done cycle.
  task automatic run_copy(input int n, input int s, input int d, input bit w, input bit poke);
    int cyc = 0;
    bit busy_ok = 1;
    int r0, w0;
    @(negedge clk);
    r0 = rd_cnt; w0 = wr_cnt;
    size_word = w; cnt_in = CW'(n); src_in = AW'(s); dst_in = AW'(d); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    size_word = ~w; cnt_in = CW'(5); src_in = AW'(16); dst_in = AW'(600);
    forever begin
      cyc++;
      if (!busy) busy_ok = 0;
      if (done) break;
      if (cyc > 5*n + 10) break;
      start = poke && (cyc == 3);
      @(negedge clk);
    end
    start = poke;
    chk(done === 1'b1, "R8 done seen", {31'd0, done}, 1);
    chk(cyc == 5*n + 1, "R8 cycles to done", cyc, 5*n + 1);
    chk(busy_ok, "R9 busy through run", {31'd0, busy_ok}, 1);
    @(negedge clk);
    start = 1'b0;
    chk(!done && !busy, "R9/R2 idle after done", {30'd0, busy, done}, 0);
    ref_copy(n, s, d, w);
    chk(cnt_out == 0, "R7 final count", cnt_out, 0);
    chk(src_out == AW'(s + n*stride_of(w)), "R6 final src", src_out, s + n*stride_of(w));
    chk(dst_out == AW'(d + n*stride_of(w)), "R6 final dst", dst_out, d + n*stride_of(w));
    chk(rd_cnt - r0 == n && wr_cnt - w0 == n, "R10 access count",
        rd_cnt - r0 + wr_cnt - w0, 2*n);
    compare_mem(w ? "R5 word copy image" : "R4 byte copy image");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int w = 0; w < 256; w++) begin
      mem[w] = $urandom;
      for (int b = 0; b < 4; b++) ref_b[4*w+b] = mem[w][8*b +: 8];
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 reset state", {29'd0, busy, done, mem_req}, 0);

    // R3: zero count, no access, registers hold loaded values
    begin
      int r0 = rd_cnt, w0 = wr_cnt;
      size_word = 1'b0; cnt_in = '0; src_in = 16'd33; dst_in = 16'd700; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(done === 1'b1, "R3 zero count done next cycle", {31'd0, done}, 1);
      chk(src_out == 16'd33 && dst_out == 16'd700 && cnt_out == 0, "R3 registers kept",
          src_out, 33);
      @(negedge clk);
      chk(rd_cnt == r0 && wr_cnt == w0, "R3 no access", rd_cnt - r0 + wr_cnt - w0, 0);
    end

    // R4 directed lane combinations
    run_copy(6, 1, 514, 1'b0, 1'b0);
    run_copy(5, 3, 600, 1'b0, 1'b1);
    // R5 single word and a longer word run
    run_copy(1, 40, 800, 1'b1, 1'b0);
    run_copy(12, 100, 520, 1'b1, 1'b1);

    // R1: reset in the middle of a copy
    @(negedge clk);
    size_word = 1'b1; cnt_in = 16'd8; src_in = 16'd200; dst_in = 16'd900; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !mem_req, "R1 reset mid-run", {29'd0, busy, done, mem_req}, 0);
    for (int w = 0; w < 256; w++)
      for (int b = 0; b < 4; b++) ref_b[4*w+b] = mem[w][8*b +: 8];

    // Random mix
    for (int k = 0; k < 30; k++) begin
      bit w = 1'($urandom % 2);
      int n = int'($urandom % 13);
      int s = int'($urandom % 380);
      int d = 512 + int'($urandom % 380);
      if (w) begin s = s & ~3; d = d & ~3; end
      run_copy(n, s, d, w, 1'($urandom % 2));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule